// File: doc/BRIEF.md
# Program Counter with Reset and Interrupt Vectors

This block holds the 13-bit program counter of a small microcontroller core and turns it into a fetch address for a 14-bit-wide instruction store. The logical space the counter spans is 8K words, but the physical store is only a power-of-two fraction of that, set by a parameter (1K or 2K words in normal use). The fetch address keeps only the low bits of the counter, so any address above the implemented store aliases onto the matching word inside it. The counter itself keeps all 13 bits, so a call or an interrupt can save the full value as a return address.

Each cycle the counter takes one of four actions. The highest-priority action is reset, which returns it to word 0000h. An accepted interrupt comes next and forces it to word 0004h. An absolute load for jumps and calls is third. A plain increment for the next sequential fetch is last. If none of these is requested, the counter holds. When an interrupt is taken, the counter value from just before the vector is shown on a return-address output, and a strobe marks it valid for one cycle. The decoder, the call stack and the store contents sit outside this block.

Top module: `pc_vectors`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, pc and fetch_addr are 0000h and ret_valid is 0.
- R2: When inc_en is 1 and load_en and irq_take are both 0 at a rising edge, pc becomes the old pc plus one. When all three are 0, pc holds its value.
- R3: When load_en is 1 and irq_take is 0 at a rising edge, pc becomes load_addr with all 13 bits kept, whatever the value of inc_en.
- R4: When irq_take is 1 at a rising edge, pc becomes 0004h, whatever the values of load_en and inc_en.
- R5: fetch_addr equals pc modulo PHYS_WORDS. Its low log2(PHYS_WORDS) bits follow pc and its upper bits are 0, so 0C05h aliases to 0405h with 2K words and to 0005h with 1K words.
- R6: In the cycle after a rising edge with irq_take at 1, ret_valid is 1 and ret_addr holds the pc value from before that edge. ret_valid is 0 in any cycle that does not follow such an edge.
- R7: An increment from 1FFFh wraps pc to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Advance to the next sequential word |
| load_en | input | 1 | Load an absolute target |
| load_addr | input | 13 | Jump or call target |
| irq_take | input | 1 | Interrupt accepted; enter the vector |
| pc | output | 13 | Full logical program counter |
| fetch_addr | output | 13 | Physical fetch address with the upper bits cleared |
| ret_addr | output | 13 | Counter value from before the vector |
| ret_valid | output | 1 | One-cycle strobe marking ret_addr valid |

## Verification
The assertions check on every cycle that the counter's next value follows the priority order, meaning vector over load over increment over hold. They also check that the return strobe appears only after an accepted interrupt and carries the counter value from before the vector. The bench scenarios are needed for the things the properties cannot show: aliasing of high targets in both store sizes, the 1FFFh-to-0000h wrap, a reset arriving while requests are still active, and back-to-back interrupts. For these, the bench compares both store sizes against a behavioural model on every clock.

// File: rtl/pc_vectors.sv
module pc_vectors #(
  parameter int PC_W       = 13,
  parameter int PHYS_WORDS = 2048,
  parameter int RESET_VEC  = 0,
  parameter int IRQ_VEC    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_en,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_addr,
  input  logic            irq_take,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] fetch_addr,
  output logic [PC_W-1:0] ret_addr,
  output logic            ret_valid
);

  localparam logic [PC_W-1:0] PHYS_MASK = PC_W'(PHYS_WORDS - 1);
  localparam logic [PC_W-1:0] RST_PC    = PC_W'(RESET_VEC);
  localparam logic [PC_W-1:0] IRQ_PC    = PC_W'(IRQ_VEC);

  assign fetch_addr = pc & PHYS_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= RST_PC;
      ret_addr  <= '0;
      ret_valid <= 1'b0;
    end else begin
      ret_valid <= irq_take;
      if (irq_take) begin
        ret_addr <= pc;
        pc       <= IRQ_PC;
      end else if (load_en) begin
        pc <= load_addr;
      end else if (inc_en) begin
        pc <= pc + 1'b1;
      end
    end
  end

  // R4
  vector_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc == IRQ_PC);

  // R3
  load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !irq_take) |=> pc == $past(load_addr));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !load_en && !irq_take) |=> pc == PC_W'($past(pc) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !load_en && !irq_take) |=> $stable(pc));

  // R6
  ret_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (ret_valid && ret_addr == $past(pc)));

  // R6
  ret_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |=> !ret_valid);

endmodule

// File: tb/pc_vectors_tb.sv
module pc_vectors_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 1'b0, load_en = 1'b0, irq_take = 1'b0;
  logic [12:0] load_addr = '0;
  logic [12:0] pc, fa, ra, pc_s, fa_s, ra_s;
  logic        rv, rv_s;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pc = 0, m_ra = 0, m_rv = 0;

  always #10 clk = ~clk;

  pc_vectors #(.PHYS_WORDS(2048)) u_dut (.clk(clk), .rst_n(rst_n), .inc_en(inc_en),
    .load_en(load_en), .load_addr(load_addr), .irq_take(irq_take),
    .pc(pc), .fetch_addr(fa), .ret_addr(ra), .ret_valid(rv));

  pc_vectors #(.PHYS_WORDS(1024)) u_small (.clk(clk), .rst_n(rst_n), .inc_en(inc_en),
    .load_en(load_en), .load_addr(load_addr), .irq_take(irq_take),
    .pc(pc_s), .fetch_addr(fa_s), .ret_addr(ra_s), .ret_valid(rv_s));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " pc"}, int'(pc), m_pc);
    chk({tag, " pc_small"}, int'(pc_s), m_pc);
    chk("R5 fetch 2K", int'(fa), m_pc % 2048);
    chk("R5 fetch 1K", int'(fa_s), m_pc % 1024);
    chk("R6 ret_valid", int'(rv), m_rv);
    chk("R6 ret_valid small", int'(rv_s), m_rv);
    if (m_rv != 0) begin
      chk("R6 ret_addr", int'(ra), m_ra);
      chk("R6 ret_addr small", int'(ra_s), m_ra);
    end
  endtask

  task automatic step(string tag, bit inc, bit ld, int addr, bit irq);
    inc_en = inc; load_en = ld; load_addr = 13'(addr); irq_take = irq;
    @(posedge clk);
    m_rv = irq;
    if (irq) begin m_ra = m_pc; m_pc = 4; end
    else if (ld) m_pc = addr % 8192;
    else if (inc) m_pc = (m_pc + 1) % 8192;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    inc_en = 1'b1; load_en = 1'b1; irq_take = 1'b1; load_addr = 13'h0abc;
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    inc_en = 1'b0; load_en = 1'b0; irq_take = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    for (int i = 0; i < 5; i++) step("R2 inc", 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R2 hold", 0, 0, 0, 0);
    step("R3 load over inc", 1, 1, 'h0C05, 0);
    step("R2 inc after alias", 1, 0, 0, 0);
    step("R3 load", 0, 1, 'h07FF, 0);
    step("R5 cross 2K", 1, 0, 0, 0);
    step("R4 irq over load", 1, 1, 'h1111, 1);
    step("R2 inc after vector", 1, 0, 0, 0);
    step("R4 irq", 0, 0, 0, 1);
    step("R4 irq back to back", 0, 0, 0, 1);
    step("R6 strobe drop", 0, 0, 0, 0);
    step("R3 load top", 0, 1, 'h1FFE, 0);
    step("R7 inc", 1, 0, 0, 0);
    step("R7 wrap", 1, 0, 0, 0);
    step("R7 after wrap", 1, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 8);
      step("R2,R3,R4 mixed", r[0], r[1] & r[2], int'($urandom % 8192), (r == 7));
    end

    step("R3 load before reset", 0, 1, 'h1ABC, 0);
    inc_en = 1'b1; load_en = 1'b1; irq_take = 1'b1;
    #3 rst_n = 1'b0;
    m_pc = 0; m_rv = 0;
    #2 compare("R1 async reset");
    @(negedge clk);
    compare("R1 held in reset");
    inc_en = 1'b0; load_en = 1'b0; irq_take = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 released");
    step("R2 first inc", 1, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule